// File: doc/BRIEF.md
# Configurable Interleaved Multiphase PWM Generator

This block drives four digital PWM phase outputs that feed one or two regulated output rails (channels A and B). A 3-bit layout code chooses how the four phase outputs are shared between the channels: four dual-rail layouts and four single-rail layouts with one to four phases. All phases of a channel share that channel's 8-bit duty command. Their pulses are staggered evenly across the switching period, which is counted by a single free-running sweep counter. The sweep length comes from a 3-bit frequency select.

An external power sequencer gives each channel an enable and a high-impedance request. A phase that is not used, or whose channel is disabled or asked to float, is not driven. Its output-enable pin is low and its data pin reads 0. Very short pulses and very short gaps are never produced. A command too small for the minimum on-time gives a constant low. A command that leaves less than the minimum off-time gives a constant high.

Top module: `mphase_pwm_gen`

## Requirements
- R1: Layout code `cfg_code_i` maps phases 0..3 to channels as follows. Dual-rail codes: 000 gives A={0}, B={3}; 001 gives A={0,1}, B={3}; 010 gives A={0,1,2}, B={3}; 011 gives A={0,1}, B={2,3}. Single-rail codes 1nn put phases 0..nn on A, and channel B has no phases. Within a channel, the slot number k counts up from its lowest phase.
- R2: A phase that is not used in the current layout has `pwm_oe_o` low. Any phase whose `pwm_oe_o` is low reads 0 on `pwm_o`.
- R3: Out of reset, every `pwm_oe_o` and `pwm_o` bit is 0. A phase's output enable follows its channel's `en_i` bit (bit 0 = A, bit 1 = B) one clock later.
- R4: While `hiz_i` is high for a channel, that channel's phases are not driven, one clock later. The other channel is unaffected.
- R5: With a normal command, each used phase is high for exactly on = floor(duty*P/256) clocks in every period of P clocks.
- R6: Frequency select values 0..7 pick 200, 300, 400, 500, 600, 800, 1000 and 1200 kHz. P = floor(CLK_KHZ/f).
- R7: In a channel of N phases, the pulse of slot k rises floor(k*P/N) clocks after the pulse of slot 0.
- R8: If on < MIN_ON_CLK, the channel's outputs stay low for the whole period.
- R9: If on >= MIN_ON_CLK and P-on < MIN_OFF_CLK, the channel's outputs stay high for the whole period.
- R10: While a phase stays driven, every high pulse lasts at least MIN_ON_CLK clocks. Every low gap that follows a high pulse lasts at least MIN_OFF_CLK clocks.
- R11: The layout code and frequency select are taken only while both channels are disabled. The sweep counter is held at 0 during that time and starts counting when any channel is enabled.
- R12: Each phase takes its channel's command at the end of its own period. After enable, a phase drives low until its first period end, so with the counter starting from 0, slot 0's first pulse begins P+1 clocks after enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_code_i | input | 3 | Phase-to-channel layout code |
| fsel_i | input | 3 | Switching frequency select |
| duty_a_i | input | DUTY_W | Channel A duty, fraction of 256 |
| duty_b_i | input | DUTY_W | Channel B duty, fraction of 256 |
| en_i | input | 2 | Channel enables (bit 0 = A, bit 1 = B) |
| hiz_i | input | 2 | Channel high-impedance requests |
| pwm_o | output | 4 | Phase PWM data |
| pwm_oe_o | output | 4 | Phase output enables (0 = high impedance) |

## Verification
Some rules are checked by the assertions on every cycle. These are the pulse-width floors on each phase, undriven phases reading low, the loss of drive when both channels are off or floated, the sweep counter staying below the period, and the period holding steady while a channel runs. The bench scenarios are needed for the rest. Only they can show the per-layout channel assignment, the exact high count for a given command and frequency, the stagger between slots, where the clamps take over, and the delay of the first pulse after enable.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  localparam int PHASES = 4;
  localparam int CHANS  = 2;
  localparam int NFREQ  = 8;

  typedef struct packed {
    logic       used;
    logic       owner;
    logic [1:0] slot;
    logic [2:0] width;
  } slot_t;

  function automatic int unsigned freq_khz(input int unsigned sel);
    case (sel)
      0: return 200;
      1: return 300;
      2: return 400;
      3: return 500;
      4: return 600;
      5: return 800;
      6: return 1000;
      default: return 1200;
    endcase
  endfunction

  function automatic slot_t slot_of(input logic [2:0] code, input logic [1:0] ph);
    slot_t      s;
    logic [2:0] n1;
    s  = '0;
    n1 = {1'b0, code[1:0]} + 3'd1;
    if (code[2]) begin
      s.used  = ({1'b0, ph} < n1);
      s.owner = 1'b0;
      s.slot  = ph;
      s.width = n1;
    end else if (code[1:0] == 2'b11) begin
      s.used  = 1'b1;
      s.owner = ph[1];
      s.slot  = {1'b0, ph[0]};
      s.width = 3'd2;
    end else if (ph == 2'd3) begin
      s.used  = 1'b1;
      s.owner = 1'b1;
      s.slot  = 2'd0;
      s.width = 3'd1;
    end else if ({1'b0, ph} < n1) begin
      s.used  = 1'b1;
      s.owner = 1'b0;
      s.slot  = ph;
      s.width = n1;
    end
    return s;
  endfunction
endpackage

// File: rtl/mpg_cfg_reg.sv
module mpg_cfg_reg #(
  parameter int CLK_KHZ = 100000,
  parameter int CW      = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_i,
  input  logic [2:0]    code_i,
  input  logic [2:0]    fsel_i,
  output logic [2:0]    code_o,
  output logic [CW-1:0] per_o
);
  localparam logic [CW-1:0] PER_RST = CW'(CLK_KHZ / 200);

  logic [CW-1:0] per_tab [mpg_pkg::NFREQ];
  logic [2:0]    code_q, code_n;
  logic [CW-1:0] per_q, per_n;

  for (genvar s = 0; s < mpg_pkg::NFREQ; s++) begin : g_tab
    assign per_tab[s] = CW'(CLK_KHZ / mpg_pkg::freq_khz(s));
  end

  always_comb begin
    code_n = code_q;
    per_n  = per_q;
    if (idle_i) begin
      code_n = code_i;
      per_n  = per_tab[fsel_i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      per_q  <= PER_RST;
    end else if (idle_i) begin
      code_q <= code_n;
      per_q  <= per_n;
    end
  end

  assign code_o = code_q;
  assign per_o  = per_q;
endmodule

// File: rtl/mpg_sweep.sv
module mpg_sweep #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_i,
  input  logic [CW-1:0] per_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          wrap;

  always_comb begin
    wrap = (cnt_q == per_i - CW'(1));
    if (idle_i || wrap) cnt_n = '0;
    else                cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mpg_duty.sv
module mpg_duty #(
  parameter int CW          = 9,
  parameter int DUTY_W      = 8,
  parameter int MIN_ON_CLK  = 5,
  parameter int MIN_OFF_CLK = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [CW-1:0]     per_i,
  output logic [CW-1:0]     on_o,
  output logic              zero_o,
  output logic              full_o
);
  localparam int PW = CW + DUTY_W;

  logic [PW-1:0] prod;
  logic [CW-1:0] on_n, off_n, on_q;
  logic          zero_n, full_n, zero_q, full_q;

  always_comb begin
    prod   = {{CW{1'b0}}, duty_i} * {{DUTY_W{1'b0}}, per_i};
    on_n   = prod[PW-1:DUTY_W];
    off_n  = per_i - on_n;
    zero_n = (on_n < CW'(MIN_ON_CLK));
    full_n = !zero_n && (off_n < CW'(MIN_OFF_CLK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= '0;
      zero_q <= 1'b1;
      full_q <= 1'b0;
    end else begin
      on_q   <= on_n;
      zero_q <= zero_n;
      full_q <= full_n;
    end
  end

  assign on_o   = on_q;
  assign zero_o = zero_q;
  assign full_o = full_q;
endmodule

// File: rtl/mpg_phase.sv
module mpg_phase #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] off_i,
  input  logic [CW-1:0] on_i,
  input  logic          zero_i,
  input  logic          full_i,
  input  logic          sync_i,
  input  logic          armed_i,
  output logic          pwm_o,
  output logic          oe_o
);
  logic [CW-1:0] pos, on_q;
  logic          zero_q, full_q, run_q, pwm_q, oe_q;
  logic          bound, load_en, high, run_n, pwm_n;

  always_comb begin
    if (cnt_i >= off_i) pos = cnt_i - off_i;
    else                pos = cnt_i + (per_i - off_i);
    bound   = (pos == per_i - CW'(1));
    load_en = bound || sync_i;
    high    = full_q || (!zero_q && (pos < on_q));
    run_n   = armed_i && (run_q || bound);
    pwm_n   = run_n && high;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= '0;
      zero_q <= 1'b1;
      full_q <= 1'b0;
    end else if (load_en) begin
      on_q   <= on_i;
      zero_q <= zero_i;
      full_q <= full_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pwm_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      run_q <= run_n;
      pwm_q <= pwm_n;
      oe_q  <= armed_i;
    end
  end

  assign pwm_o = pwm_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/mphase_pwm_gen.sv
module mphase_pwm_gen #(
  parameter int CLK_KHZ     = 100000,
  parameter int DUTY_W      = 8,
  parameter int MIN_ON_CLK  = 5,
  parameter int MIN_OFF_CLK = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_code_i,
  input  logic [2:0]        fsel_i,
  input  logic [DUTY_W-1:0] duty_a_i,
  input  logic [DUTY_W-1:0] duty_b_i,
  input  logic [1:0]        en_i,
  input  logic [1:0]        hiz_i,
  output logic [3:0]        pwm_o,
  output logic [3:0]        pwm_oe_o
);
  import mpg_pkg::*;

  localparam int PER_MAX = CLK_KHZ / 200;
  localparam int CW      = $clog2(PER_MAX + 1);

  logic          idle;
  logic [2:0]    code_q;
  logic [CW-1:0] per_q, cnt_q;
  logic [CW-1:0] ch_on   [CHANS];
  logic [CHANS-1:0] ch_zero, ch_full;

  function automatic logic [CW-1:0] offset_of(input slot_t s, input logic [CW-1:0] per);
    logic [CW+1:0] prod;
    prod = {2'b00, per} * {{CW{1'b0}}, s.slot};
    case (s.width)
      3'd2:    return CW'(prod >> 1);
      3'd3:    return CW'(prod / (CW+2)'(3));
      3'd4:    return CW'(prod >> 2);
      default: return '0;
    endcase
  endfunction

  assign idle = ~|en_i;

  mpg_cfg_reg #(.CLK_KHZ(CLK_KHZ), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .idle_i(idle), .code_i(cfg_code_i), .fsel_i(fsel_i),
    .code_o(code_q), .per_o(per_q)
  );

  mpg_sweep #(.CW(CW)) u_sweep (
    .clk(clk), .rst_n(rst_n), .idle_i(idle), .per_i(per_q), .cnt_o(cnt_q)
  );

  for (genvar c = 0; c < CHANS; c++) begin : g_ch
    logic [DUTY_W-1:0] duty_sel;
    if (c == 0) begin : g_a
      assign duty_sel = duty_a_i;
    end else begin : g_b
      assign duty_sel = duty_b_i;
    end
    mpg_duty #(.CW(CW), .DUTY_W(DUTY_W), .MIN_ON_CLK(MIN_ON_CLK), .MIN_OFF_CLK(MIN_OFF_CLK)) u_duty (
      .clk(clk), .rst_n(rst_n), .duty_i(duty_sel), .per_i(per_q),
      .on_o(ch_on[c]), .zero_o(ch_zero[c]), .full_o(ch_full[c])
    );
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_ph
    slot_t         sl;
    logic [CW-1:0] off;
    logic          armed;
    always_comb begin
      sl    = slot_of(code_q, 2'(p));
      off   = offset_of(sl, per_q);
      armed = sl.used && en_i[sl.owner] && !hiz_i[sl.owner];
    end
    mpg_phase #(.CW(CW)) u_phase (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt_q), .per_i(per_q), .off_i(off),
      .on_i(ch_on[sl.owner]), .zero_i(ch_zero[sl.owner]), .full_i(ch_full[sl.owner]),
      .sync_i(idle), .armed_i(armed), .pwm_o(pwm_o[p]), .oe_o(pwm_oe_o[p])
    );
  end
endmodule

// File: rtl/mpg_chk.sv
module mpg_chk #(
  parameter int CW          = 9,
  parameter int MIN_ON_CLK  = 5,
  parameter int MIN_OFF_CLK = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    en_i,
  input logic [1:0]    hiz_i,
  input logic [3:0]    pwm_o,
  input logic [3:0]    pwm_oe_o,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] per_q
);
  a_r3_idle_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == 2'b00) |=> (pwm_oe_o == 4'b0000));

  a_r4_float_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_i == 2'b11) |=> (pwm_oe_o == 4'b0000));

  a_r11_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i != 2'b00) |=> $stable(per_q));

  a_r6_sweep_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < per_q);

  for (genvar p = 0; p < 4; p++) begin : g_mon
    logic [15:0] hi_len, lo_len;
    logic        prev, lo_ok;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_len <= '0;
        lo_len <= '0;
        prev   <= 1'b0;
        lo_ok  <= 1'b0;
      end else begin
        prev <= pwm_o[p];
        if (pwm_o[p]) hi_len <= (hi_len == 16'hFFFF) ? hi_len : hi_len + 16'd1;
        else          hi_len <= '0;
        if (pwm_oe_o[p] && !pwm_o[p]) lo_len <= (lo_len == 16'hFFFF) ? lo_len : lo_len + 16'd1;
        else                          lo_len <= '0;
        if (!pwm_oe_o[p])              lo_ok <= 1'b0;
        else if (prev && !pwm_o[p])    lo_ok <= 1'b1;
      end
    end

    a_r2_undriven_low: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_oe_o[p] |-> !pwm_o[p]);

    a_r10_min_on: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pwm_o[p]) && pwm_oe_o[p]) |-> (hi_len >= 16'(MIN_ON_CLK)));

    a_r10_min_off: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwm_o[p]) && lo_ok) |-> (lo_len >= 16'(MIN_OFF_CLK)));
  end
endmodule

bind mphase_pwm_gen mpg_chk #(.CW(CW), .MIN_ON_CLK(MIN_ON_CLK), .MIN_OFF_CLK(MIN_OFF_CLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .hiz_i(hiz_i), .pwm_o(pwm_o),
  .pwm_oe_o(pwm_oe_o), .cnt_q(cnt_q), .per_q(per_q)
);

// File: tb/sim_mphase_pwm_gen.sv
module sim_mphase_pwm_gen;
  localparam int CLK_PERIOD  = 10;
  localparam int CLK_KHZ     = 100000;
  localparam int MIN_ON_CLK  = 5;
  localparam int MIN_OFF_CLK = 16;
  localparam int NVEC        = 14;

  // {code[21:19], fsel[18:16], duty_a[15:8], duty_b[7:0]}
  localparam logic [21:0] VEC [NVEC] = '{
    {3'b000, 3'd0, 8'd128, 8'd64},
    {3'b001, 3'd2, 8'd100, 8'd200},
    {3'b010, 3'd4, 8'd77,  8'd128},
    {3'b011, 3'd5, 8'd50,  8'd180},
    {3'b100, 3'd1, 8'd90,  8'd0},
    {3'b101, 3'd3, 8'd128, 8'd0},
    {3'b110, 3'd6, 8'd200, 8'd0},
    {3'b111, 3'd7, 8'd128, 8'd0},
    {3'b111, 3'd0, 8'd1,   8'd0},
    {3'b011, 3'd7, 8'd255, 8'd3},
    {3'b100, 3'd2, 8'd6,   8'd0},
    {3'b100, 3'd2, 8'd5,   8'd0},
    {3'b101, 3'd2, 8'd240, 8'd0},
    {3'b101, 3'd2, 8'd241, 8'd0}
  };

  logic       clk, rst_n;
  logic [2:0] cfg_code, fsel;
  logic [7:0] duty_a, duty_b;
  logic [1:0] en, hiz;
  logic [3:0] pwm, pwm_oe;

  int n_chk = 0;
  int n_err = 0;
  int viol  = 0;
  int m_hi   [4];
  int m_rise [4];

  mphase_pwm_gen #(.CLK_KHZ(CLK_KHZ), .DUTY_W(8), .MIN_ON_CLK(MIN_ON_CLK), .MIN_OFF_CLK(MIN_OFF_CLK)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_code_i(cfg_code), .fsel_i(fsel),
    .duty_a_i(duty_a), .duty_b_i(duty_b), .en_i(en), .hiz_i(hiz),
    .pwm_o(pwm), .pwm_oe_o(pwm_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int per_of(input int sel);
    int khz [8] = '{200, 300, 400, 500, 600, 800, 1000, 1200};
    return CLK_KHZ / khz[sel];
  endfunction

  function automatic int exp_on(input int d, input int p);
    int on = (d * p) / 256;
    if (on < MIN_ON_CLK) return 0;
    if (p - on < MIN_OFF_CLK) return p;
    return on;
  endfunction

  // phase layout expected from the layout-code requirement
  function automatic void exp_map(input logic [2:0] c, input int ph,
                                  output bit used, output int ch, output int slot, output int w);
    int na;
    used = 0; ch = 0; slot = ph; w = 1;
    if (c[2]) begin
      na = int'(c[1:0]) + 1;
      if (ph < na) begin used = 1; w = na; end
    end else if (c == 3'b011) begin
      used = 1; w = 2;
      if (ph >= 2) begin ch = 1; slot = ph - 2; end
    end else begin
      na = (c == 3'b000) ? 1 : (c == 3'b001) ? 2 : 3;
      if (ph == 3) begin used = 1; ch = 1; slot = 0; w = 1; end
      else if (ph < na) begin used = 1; w = na; end
    end
  endfunction

  // pulse width monitor over all runs (R10)
  logic [3:0] mon_prev = '0;
  int hl [4] = '{0, 0, 0, 0};
  int ll [4] = '{0, 0, 0, 0};
  bit lok [4] = '{0, 0, 0, 0};
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 4; i++) begin
        if (pwm[i] && !mon_prev[i] && lok[i] && ll[i] < MIN_OFF_CLK) viol++;
        if (!pwm[i] && mon_prev[i] && pwm_oe[i] && hl[i] < MIN_ON_CLK) viol++;
        if (!pwm_oe[i]) lok[i] = 0;
        else if (!pwm[i] && mon_prev[i]) lok[i] = 1;
        hl[i] = pwm[i] ? hl[i] + 1 : 0;
        ll[i] = (pwm_oe[i] && !pwm[i]) ? ll[i] + 1 : 0;
      end
      mon_prev = pwm;
    end
  end

  task automatic measure(input int p);
    logic [3:0] prev;
    prev = pwm;
    for (int i = 0; i < 4; i++) begin m_hi[i] = 0; m_rise[i] = -1; end
    for (int j = 0; j < p; j++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        if (pwm[i]) m_hi[i]++;
        if (pwm[i] && !prev[i]) m_rise[i] = j;
      end
      prev = pwm;
    end
  endtask

  task automatic start_run(input logic [2:0] c, input logic [2:0] f, input logic [7:0] da, input logic [7:0] db);
    en = 2'b00; hiz = 2'b00;
    repeat (2) @(negedge clk);
    cfg_code = c; fsel = f; duty_a = da; duty_b = db;
    repeat (3) @(negedge clk);
    en = 2'b11;
  endtask

  task automatic run_vec(input logic [21:0] v);
    logic [2:0] c;
    int p, d, e, r, diff, ex;
    bit used;
    int ch, slot, w;
    c = v[21:19];
    p = per_of(int'(v[18:16]));
    start_run(c, v[18:16], v[15:8], v[7:0]);
    repeat (3 * p + 10) @(negedge clk);
    measure(p);
    for (int i = 0; i < 4; i++) begin
      exp_map(c, i, used, ch, slot, w);
      check(pwm_oe[i] == used, "R2 phase drive per layout", int'(pwm_oe[i]), int'(used));
      if (used) begin
        d = (ch == 0) ? int'(v[15:8]) : int'(v[7:0]);
        e = exp_on(d, p);
        if (e == 0)      check(m_hi[i] == e, "R8 low clamp", m_hi[i], e);
        else if (e == p) check(m_hi[i] == e, "R9 high clamp", m_hi[i], e);
        else             check(m_hi[i] == e, "R1 R5 R6 high count", m_hi[i], e);
        if (slot > 0 && e > 0 && e < p) begin
          r = (ch == 0) ? 0 : ((c == 3'b011) ? 2 : 3);
          diff = (m_rise[i] - m_rise[r] + p) % p;
          ex = (slot * p) / w;
          check(diff == ex, "R7 stagger", diff, ex);
        end
      end else begin
        check(m_hi[i] == 0, "R2 unused phase low", m_hi[i], 0);
      end
    end
  endtask

  initial begin
    int hi_cnt, cyc;
    rst_n = 1'b0; cfg_code = 3'b000; fsel = 3'd0; duty_a = 8'd0; duty_b = 8'd0;
    en = 2'b00; hiz = 2'b00;
    repeat (4) @(negedge clk);
    check(pwm_oe == 4'b0000, "R3 reset oe", int'(pwm_oe), 0);
    check(pwm == 4'b0000, "R3 reset pwm", int'(pwm), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(pwm_oe == 4'b0000, "R3 idle after reset", int'(pwm_oe), 0);

    for (int v = 0; v < NVEC; v++) run_vec(VEC[v]);

    // R12: first pulse after enable, one phase, P = 83, on = 41
    en = 2'b00;
    repeat (2) @(negedge clk);
    cfg_code = 3'b100; fsel = 3'd7; duty_a = 8'd128;
    repeat (3) @(negedge clk);
    en = 2'b01;
    hi_cnt = 0;
    @(negedge clk);
    check(pwm_oe[0] == 1'b1, "R3 enable drives", int'(pwm_oe[0]), 1);
    if (pwm[0]) hi_cnt++;
    for (int j = 1; j < 83; j++) begin
      @(negedge clk);
      if (pwm[0]) hi_cnt++;
    end
    check(hi_cnt == 0, "R12 low until period end", hi_cnt, 0);
    @(negedge clk);
    check(pwm[0] == 1'b1, "R12 first pulse start", int'(pwm[0]), 1);

    // R12: command change takes effect, on = floor(64*83/256) = 20
    duty_a = 8'd64;
    repeat (3 * 83) @(negedge clk);
    measure(83);
    check(m_hi[0] == 20, "R12 new command", m_hi[0], 20);

    // R11: layout and frequency ignored while running
    cfg_code = 3'b111; fsel = 3'd0;
    repeat (3 * 83) @(negedge clk);
    measure(83);
    check(m_hi[0] == 20, "R11 period kept", m_hi[0], 20);
    check(pwm_oe[1] == 1'b0, "R11 layout kept", int'(pwm_oe[1]), 0);

    // R6: rise to rise distance at 1200 kHz
    while (!(pwm[0] && !mon_prev[0])) @(negedge clk);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!(pwm[0] && !mon_prev[0]) && cyc < 1000);
    check(cyc == 83, "R6 period", cyc, 83);

    // R4: float channel A in a 2+2 layout, P = 125, on = 62
    start_run(3'b011, 3'd5, 8'd128, 8'd128);
    repeat (3 * 125) @(negedge clk);
    hiz = 2'b01;
    repeat (2) @(negedge clk);
    check(pwm_oe == 4'b1100, "R4 A floated", int'(pwm_oe), 12);
    measure(125);
    check(m_hi[0] + m_hi[1] == 0, "R4 A floated low", m_hi[0] + m_hi[1], 0);
    check(m_hi[3] == 62, "R4 B unaffected", m_hi[3], 62);
    hiz = 2'b00;
    repeat (2) @(negedge clk);
    check(pwm_oe == 4'b1111, "R4 A released", int'(pwm_oe), 15);

    // R3: disable channel B only
    en = 2'b01;
    repeat (2) @(negedge clk);
    check(pwm_oe == 4'b0011, "R3 B disabled", int'(pwm_oe), 3);
    repeat (2 * 125) @(negedge clk);
    measure(125);
    check(m_hi[0] == 62, "R3 A keeps running", m_hi[0], 62);

    check(viol == 0, "R10 pulse width floors", viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule